// File: doc/BRIEF.md
# DRAM Page-Mode Burst Sequencer

This block drives the strobes, multiplexed address lines and data pins of a 64K x 1 dynamic RAM so that a host can stream column accesses into one open row. The first beat of a burst supplies the row; the sequencer lowers RAS once with that row on the address lines. It then runs one CAS pulse per beat, with the beat's column on the address lines. A write beat lowers WE and presents its data bit for the whole CAS pulse. A read beat samples the memory's output bit at the end of the CAS pulse and returns it on a one-cycle strobe. Read results come back in stream order.

A row stays open until one of three events closes it. The host marks a beat as the last of its burst, the per-row beat budget runs out, or another beat would push the RAS-low time beyond the allowed maximum. The maximum is a parameter that picks either the normal or the extended page limit. When the row closes for the budget or for the time limit, the sequencer precharges and reopens the same row, and the rest of the burst continues there. Beats enter through a valid/ready handshake into a single holding slot. Ready is low while a row is being opened or precharged.

All timings are counted in clock cycles and set by parameters: RAS-to-CAS delay, CAS low width, CAS high gap inside a page, RAS precharge, and the two RAS-low maxima.

Top module: `page_burst_seq`

## Requirements
- R1: While reset is applied, and after it until a beat arrives, `dram_ras_n`, `dram_cas_n` and `dram_we_n` are high, `rd_valid` is low and `s_ready` is high.
- R2: On each RAS fall `dram_addr` carries the burst's row, and RAS stays low at least `T_RCD` cycles before the first CAS fall. Each CAS fall carries the column of the next beat in stream order. The `s_row` field of any beat other than the first of a burst is ignored. CAS is low only while RAS is low.
- R3: Every CAS low pulse lasts exactly `CAS_LOW` cycles. Between two CAS pulses of the same row, CAS stays high at least `CP` cycles.
- R4: Between a RAS rise and the next RAS fall, RAS stays high at least `T_RP` cycles.
- R5: A write beat holds `dram_we_n` low and `dram_din` equal to its data bit for every cycle of its CAS pulse. A read beat holds `dram_we_n` high for its whole CAS pulse.
- R6: A read beat samples `dram_dout` in the last cycle of its CAS pulse. `rd_valid` pulses for one cycle, in the cycle in which CAS rises, with that bit on `rd_data`. Results come back in beat order.
- R7: After the CAS pulse of a beat with `s_last` = 1, RAS rises in the same cycle as CAS. The next beat opens a row using its own `s_row`.
- R8: One RAS period carries at most `MAX_BEATS` CAS pulses. The further beats of the burst run in a new RAS period on the same row.
- R9: RAS never stays low more than `RAS_MAX` cycles, which is `RAS_MAX_NORM` when `EXT_MODE` = 0 and `RAS_MAX_EXT` when `EXT_MODE` = 1. When the next beat could not finish in time, the row closes and the burst resumes after precharge on the same row.
- R10: `s_ready` is low during the `T_RP` precharge cycles and while a row is being opened before its first CAS fall. Outside those phases it is high whenever the holding slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| s_valid | input | 1 | Host beat valid |
| s_ready | output | 1 | Sequencer can take a beat |
| s_row | input | ADDR_W | Row, used only on the first beat of a burst |
| s_col | input | ADDR_W | Column of the beat |
| s_wr | input | 1 | 1 = write beat, 0 = read beat |
| s_wdata | input | 1 | Bit to write |
| s_last | input | 1 | Beat ends the burst |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 1 | Read result bit |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_addr | output | ADDR_W | Multiplexed row/column address |
| dram_din | output | 1 | Data bit to the memory |
| dram_dout | input | 1 | Data bit from the memory |

## Verification
The bench builds the sequencer with `T_RCD` = 2, `CAS_LOW` = 3, `CP` = 2, `T_RP` = 3, `MAX_BEATS` = 4, `RAS_MAX_NORM` = 30 and `EXT_MODE` = 0. With a 30-cycle RAS limit, a host pause of a few dozen cycles inside a burst forces an early close and reopen. With a four-beat budget, a ten-beat burst has to span exactly three row openings. These small values keep both close paths, and their interaction with the precharge and ready rules, within reach of short directed and random bursts. The memory model in the bench drives a wrong bit until the last CAS-low cycle, so a read sampled at any other cycle returns a wrong result.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_CLO,
    ST_CHI,
    ST_PRE
  } seq_state_e;

  typedef struct packed {
    logic wr;
    logic wd;
    logic last;
  } beat_ctl_t;

endpackage

// File: rtl/pbs_beat_buf.sv
module pbs_beat_buf
  import pbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_ok,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_row,
  input  logic [ADDR_W-1:0] in_col,
  input  beat_ctl_t         in_ctl,
  input  logic              pop,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_row,
  output logic [ADDR_W-1:0] out_col,
  output beat_ctl_t         out_ctl
);

  logic              v_q, v_d;
  logic              push;
  logic [ADDR_W-1:0] row_q, col_q;
  beat_ctl_t         ctl_q;

  assign in_ready = accept_ok & ~v_q;
  assign push     = in_valid & in_ready;

  always_comb begin
    v_d = v_q;
    if (push)     v_d = 1'b1;
    else if (pop) v_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (push) begin
      row_q <= in_row;
      col_q <= in_col;
      ctl_q <= in_ctl;
    end
  end

  assign out_valid = v_q;
  assign out_row   = row_q;
  assign out_col   = col_q;
  assign out_ctl   = ctl_q;

  // R2: a held beat keeps its column and kind until it is issued
  p_hold_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (v_q && !pop) |=> (v_q && $stable(col_q) && $stable(ctl_q)));

endmodule

// File: rtl/pbs_timer.sv
module pbs_timer #(
  parameter int PH_W    = 4,
  parameter int RW      = 8,
  parameter int CAS_LOW = 9,
  parameter int CP      = 4,
  parameter int RAS_MAX = 1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            phase_clr,
  input  logic            ras_clr,
  input  logic            ras_low,
  output logic [PH_W-1:0] phase,
  output logic            fit_now,
  output logic            fit_gap
);

  localparam int LIM_NOW_I = RAS_MAX - CAS_LOW - 1;
  localparam int LIM_GAP_I = RAS_MAX - CAS_LOW - CP - 1;
  localparam logic [RW-1:0]   LIM_NOW = RW'(LIM_NOW_I);
  localparam logic [RW-1:0]   LIM_GAP = RW'(LIM_GAP_I);
  localparam logic [RW-1:0]   RAS_LIM = RW'(RAS_MAX);
  localparam logic [PH_W-1:0] PH_TOP  = '1;

  logic [PH_W-1:0] phase_q, phase_d;
  logic [RW-1:0]   ras_q, ras_d;

  always_comb begin
    phase_d = phase_q;
    if (phase_clr)             phase_d = '0;
    else if (phase_q != PH_TOP) phase_d = phase_q + 1'b1;
    ras_d = ras_q;
    if (ras_clr)      ras_d = '0;
    else if (ras_low) ras_d = ras_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= '0;
      ras_q   <= '0;
    end else begin
      phase_q <= phase_d;
      ras_q   <= ras_d;
    end
  end

  assign phase   = phase_q;
  assign fit_now = (ras_q <= LIM_NOW);
  assign fit_gap = (ras_q <= LIM_GAP);

  // R9: the RAS-low cycle count never reaches the limit while RAS is low
  p_ras_budget_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ras_low |-> (ras_q < RAS_LIM));

endmodule

// File: rtl/pbs_rd_cap.sv
module pbs_rd_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic bit_in,
  output logic rd_valid,
  output logic rd_data
);

  logic v_q, d_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= 1'b0;
    else        v_q <= cap;
  end

  always_ff @(posedge clk) begin
    if (cap) d_q <= bit_in;
  end

  assign rd_valid = v_q;
  assign rd_data  = d_q;

endmodule

// File: rtl/page_burst_seq.sv
module page_burst_seq
  import pbs_pkg::*;
#(
  parameter int ADDR_W       = 8,
  parameter int T_RCD        = 3,
  parameter int CAS_LOW      = 9,
  parameter int CP           = 4,
  parameter int T_RP         = 10,
  parameter int RAS_MAX_NORM = 1000,
  parameter int RAS_MAX_EXT  = 7500,
  parameter bit EXT_MODE     = 1'b0,
  parameter int MAX_BEATS    = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [ADDR_W-1:0] s_row,
  input  logic [ADDR_W-1:0] s_col,
  input  logic              s_wr,
  input  logic              s_wdata,
  input  logic              s_last,
  output logic              rd_valid,
  output logic              rd_data,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic [ADDR_W-1:0] dram_addr,
  output logic              dram_din,
  input  logic              dram_dout
);

  localparam int RAS_MAX = EXT_MODE ? RAS_MAX_EXT : RAS_MAX_NORM;
  localparam int PH_MAXV = (T_RCD > CAS_LOW) ?
                           ((T_RCD > T_RP) ? ((T_RCD > CP) ? T_RCD : CP) : ((T_RP > CP) ? T_RP : CP)) :
                           ((CAS_LOW > T_RP) ? ((CAS_LOW > CP) ? CAS_LOW : CP) : ((T_RP > CP) ? T_RP : CP));
  localparam int PH_W    = $clog2(PH_MAXV + 1) + 1;
  localparam int RW      = $clog2(RAS_MAX + CAS_LOW + CP + 2) + 1;
  localparam int BW      = $clog2(MAX_BEATS + 1);
  localparam logic [PH_W-1:0] PH_RCD = PH_W'(T_RCD - 1);
  localparam logic [PH_W-1:0] PH_CLO = PH_W'(CAS_LOW - 1);
  localparam logic [PH_W-1:0] PH_CP  = PH_W'(CP - 1);
  localparam logic [PH_W-1:0] PH_RP  = PH_W'(T_RP - 1);
  localparam logic [BW-1:0]   BEATS_TOP = BW'(MAX_BEATS);

  // reset: asserted at once, released on the clock
  logic [1:0] rs_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign srst_n = rs_q[1];

  seq_state_e        state_q, state_d;
  logic [ADDR_W-1:0] row_q, col_q;
  beat_ctl_t         ctl_q;
  logic              cont_q;
  logic [BW-1:0]     beats_q;

  logic              hb_valid, pop, accept_ok;
  logic [ADDR_W-1:0] hb_row, hb_col;
  beat_ctl_t         hb_ctl, s_ctl;
  logic [PH_W-1:0]   phase;
  logic              fit_now, fit_gap;
  logic              ras_low, open_start, rd_cap;

  assign s_ctl     = '{wr: s_wr, wd: s_wdata, last: s_last};
  assign accept_ok = (state_q == ST_IDLE) || (state_q == ST_CLO) || (state_q == ST_CHI);

  pbs_beat_buf #(.ADDR_W(ADDR_W)) u_buf (
    .clk       (clk),
    .rst_n     (srst_n),
    .accept_ok (accept_ok),
    .in_valid  (s_valid),
    .in_ready  (s_ready),
    .in_row    (s_row),
    .in_col    (s_col),
    .in_ctl    (s_ctl),
    .pop       (pop),
    .out_valid (hb_valid),
    .out_row   (hb_row),
    .out_col   (hb_col),
    .out_ctl   (hb_ctl)
  );

  pbs_timer #(
    .PH_W    (PH_W),
    .RW      (RW),
    .CAS_LOW (CAS_LOW),
    .CP      (CP),
    .RAS_MAX (RAS_MAX)
  ) u_timer (
    .clk       (clk),
    .rst_n     (srst_n),
    .phase_clr (state_d != state_q),
    .ras_clr   (open_start),
    .ras_low   (ras_low),
    .phase     (phase),
    .fit_now   (fit_now),
    .fit_gap   (fit_gap)
  );

  // next state
  always_comb begin
    state_d = state_q;
    pop     = 1'b0;
    unique case (state_q)
      ST_IDLE: if (hb_valid) state_d = ST_OPEN;
      ST_OPEN: if (phase == PH_RCD) begin
        state_d = ST_CLO;
        pop     = 1'b1;
      end
      ST_CLO: if (phase == PH_CLO) begin
        if (ctl_q.last || (beats_q == BEATS_TOP) || !fit_gap) state_d = ST_PRE;
        else                                                  state_d = ST_CHI;
      end
      ST_CHI: if (phase >= PH_CP) begin
        if (!fit_now) state_d = ST_PRE;
        else if (hb_valid) begin
          state_d = ST_CLO;
          pop     = 1'b1;
        end
      end
      ST_PRE: if (phase == PH_RP) state_d = hb_valid ? ST_OPEN : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign open_start = (state_d == ST_OPEN) && (state_q != ST_OPEN);
  assign ras_low    = (state_q == ST_OPEN) || (state_q == ST_CLO) || (state_q == ST_CHI);
  assign rd_cap     = (state_q == ST_CLO) && (phase == PH_CLO) && !ctl_q.wr;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      cont_q  <= 1'b0;
      beats_q <= '0;
    end else begin
      state_q <= state_d;
      if (pop) begin
        cont_q  <= ~hb_ctl.last;
        beats_q <= (state_q == ST_OPEN) ? BW'(1) : beats_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (open_start && !cont_q) row_q <= hb_row;
    if (pop) begin
      col_q <= hb_col;
      ctl_q <= hb_ctl;
    end
  end

  pbs_rd_cap u_rd (
    .clk      (clk),
    .rst_n    (srst_n),
    .cap      (rd_cap),
    .bit_in   (dram_dout),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  assign dram_ras_n = ~ras_low;
  assign dram_cas_n = ~(state_q == ST_CLO);
  assign dram_we_n  = ~((state_q == ST_CLO) && ctl_q.wr);
  assign dram_addr  = (state_q == ST_OPEN) ? row_q : col_q;
  assign dram_din   = ctl_q.wd;

  // R2: CAS pulses only inside an open row
  p_cas_under_ras_r2: assert property (@(posedge clk) disable iff (!srst_n)
    !dram_cas_n |-> !dram_ras_n);
  // R5: WE is low only during a CAS pulse
  p_we_inside_cas_r5: assert property (@(posedge clk) disable iff (!srst_n)
    !dram_we_n |-> !dram_cas_n);
  // R6: a read result appears only when CAS has just risen
  p_rd_on_cas_rise_r6: assert property (@(posedge clk) disable iff (!srst_n)
    rd_valid |-> $rose(dram_cas_n));
  // R10: no beat accepted while opening or precharging
  p_ready_shut_r10: assert property (@(posedge clk) disable iff (!srst_n)
    ((state_q == ST_OPEN) || (state_q == ST_PRE)) |-> !s_ready);
  // R8: beat budget of one RAS period
  p_beat_cap_r8: assert property (@(posedge clk) disable iff (!srst_n)
    beats_q <= BEATS_TOP);

endmodule

// File: tb/page_burst_seq_tb.sv
module page_burst_seq_tb;

  localparam int CLK_PERIOD = 10;
  localparam int T_RCD      = 2;
  localparam int CAS_LOW    = 3;
  localparam int CP         = 2;
  localparam int T_RP       = 3;
  localparam int RAS_MAX    = 30;
  localparam int MAX_BEATS  = 4;

  typedef struct {
    logic [7:0] row;
    logic [7:0] col;
    bit wr;
    bit wd;
    bit last;
  } beat_t;

  logic clk, rst_n;
  logic s_valid, s_ready, s_wr, s_wdata, s_last;
  logic [7:0] s_row, s_col;
  logic rd_valid, rd_data;
  logic dram_ras_n, dram_cas_n, dram_we_n, dram_din, dram_dout;
  logic [7:0] dram_addr;

  page_burst_seq #(
    .ADDR_W(8), .T_RCD(T_RCD), .CAS_LOW(CAS_LOW), .CP(CP), .T_RP(T_RP),
    .RAS_MAX_NORM(RAS_MAX), .RAS_MAX_EXT(60), .EXT_MODE(1'b0), .MAX_BEATS(MAX_BEATS)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_row(s_row), .s_col(s_col), .s_wr(s_wr), .s_wdata(s_wdata), .s_last(s_last),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_addr(dram_addr), .dram_din(dram_din), .dram_dout(dram_dout)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // memory model, bench shadow and scoreboards
  bit    mem    [1024];
  bit    shadow [1024];
  beat_t beat_q [$];
  bit    rd_q   [$];

  function automatic int key(input logic [7:0] row, input logic [7:0] col);
    return {row[1:0], col};
  endfunction

  // monitor state
  bit         mon_on = 1'b0;
  bit         ras_p = 1'b1, cas_p = 1'b1;
  int         ras_lo = 0, ras_hi = 1000, cas_lo = 0, cas_hi = 1000;
  bit         first_in_row = 1'b0, opening = 1'b0, had_row = 1'b0;
  int         beats_row = 0;
  int         opens = 0;
  logic [7:0] row_lat = '0;
  beat_t      cur;

  always @(negedge clk) begin
    if (mon_on) begin
      // counters
      if (!dram_ras_n) ras_lo = ras_p ? 1 : ras_lo + 1;
      else             ras_hi = ras_p ? ras_hi + 1 : 1;
      if (!dram_cas_n) cas_lo = cas_p ? 1 : cas_lo + 1;
      else             cas_hi = cas_p ? cas_hi + 1 : 1;

      // RAS fall
      if (ras_p && !dram_ras_n) begin
        chk(ras_hi >= T_RP, "R4", "RAS precharge cycles", ras_hi, T_RP);
        row_lat = dram_addr;
        opens++;
        beats_row = 0;
        first_in_row = 1'b1;
        opening = 1'b1;
      end
      // RAS rise
      if (!ras_p && dram_ras_n) begin
        chk(dram_cas_n == 1'b1, "R2", "CAS high at RAS rise", dram_cas_n, 1);
        had_row = 1'b1;
      end
      if (!dram_ras_n)
        chk(ras_lo <= RAS_MAX, "R9", "RAS low cycles", ras_lo, RAS_MAX);

      // CAS fall
      if (cas_p && !dram_cas_n) begin
        chk(!dram_ras_n, "R2", "RAS low at CAS fall", dram_ras_n, 0);
        if (first_in_row)
          chk(ras_lo - 1 >= T_RCD, "R2", "RAS to CAS cycles", ras_lo - 1, T_RCD);
        else
          chk(cas_hi >= CP, "R3", "CAS high gap", cas_hi, CP);
        first_in_row = 1'b0;
        opening = 1'b0;
        beats_row++;
        chk(beats_row <= MAX_BEATS, "R8", "beats in one row", beats_row, MAX_BEATS);
        if (beat_q.size() == 0) begin
          chk(1'b0, "R2", "unexpected CAS pulse", 1, 0);
          cur = '{row: '0, col: '0, wr: 1'b0, wd: 1'b0, last: 1'b0};
        end else begin
          cur = beat_q.pop_front();
          chk(row_lat == cur.row, "R2", "latched row", row_lat, cur.row);
          chk(dram_addr == cur.col, "R2", "column", dram_addr, cur.col);
          if (!dram_we_n) mem[key(row_lat, dram_addr)] = dram_din;
        end
      end
      // during CAS low
      if (!dram_cas_n) begin
        chk(dram_we_n == !cur.wr, "R5", "WE during CAS", dram_we_n, !cur.wr);
        if (cur.wr) chk(dram_din == cur.wd, "R5", "write data", dram_din, cur.wd);
      end
      // CAS rise
      if (!cas_p && dram_cas_n) begin
        chk(cas_lo == CAS_LOW, "R3", "CAS low width", cas_lo, CAS_LOW);
        if (cur.last) chk(dram_ras_n == 1'b1, "R7", "RAS rises with last CAS", dram_ras_n, 1);
      end

      // R10: ready shut while opening or precharging
      if (!dram_ras_n && opening)
        chk(s_ready == 1'b0, "R10", "ready during row open", s_ready, 0);
      if (dram_ras_n && had_row && ras_hi <= T_RP)
        chk(s_ready == 1'b0, "R10", "ready during precharge", s_ready, 0);

      // read results
      if (rd_valid) begin
        chk(dram_cas_n == 1'b1, "R6", "CAS high at result", dram_cas_n, 1);
        if (rd_q.size() == 0) chk(1'b0, "R6", "unexpected read result", 1, 0);
        else begin
          bit e;
          e = rd_q.pop_front();
          chk(rd_data == e, "R6", "read bit", rd_data, e);
        end
      end

      ras_p = dram_ras_n;
      cas_p = dram_cas_n;
      // memory output: valid only from the last CAS-low cycle on
      if (!dram_cas_n && cas_lo >= CAS_LOW) dram_dout = mem[key(row_lat, cur.col)];
      else                                   dram_dout = ~mem[key(row_lat, cur.col)];
    end
  end

  // host side
  logic [7:0] burst_row;

  task automatic send(input logic [7:0] row_field, input logic [7:0] col,
                      input bit wr, input bit wd, input bit last);
    beat_t b;
    b = '{row: burst_row, col: col, wr: wr, wd: wd, last: last};
    beat_q.push_back(b);
    if (wr) shadow[key(burst_row, col)] = wd;
    else    rd_q.push_back(shadow[key(burst_row, col)]);
    s_valid = 1'b1; s_row = row_field; s_col = col;
    s_wr = wr; s_wdata = wd; s_last = last;
    while (!s_ready) @(negedge clk);
    @(negedge clk);
    s_valid = 1'b0;
  endtask

  task automatic burst(input int n, input int gap, input bit rand_kind);
    burst_row = 8'($urandom);
    for (int i = 0; i < n; i++) begin
      logic [7:0] rf;
      bit wr, wd;
      rf = (i == 0) ? burst_row : 8'($urandom);
      wr = rand_kind ? bit'($urandom % 2) : (i < n / 2);
      wd = bit'($urandom % 2);
      send(rf, 8'($urandom % 16), wr, wd, i == n - 1);
      repeat (gap) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    int o0;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 1024; i++) begin mem[i] = 1'b0; shadow[i] = 1'b0; end
    s_valid = 1'b0; s_row = '0; s_col = '0; s_wr = 1'b0; s_wdata = 1'b0; s_last = 1'b0;
    dram_dout = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes in reset",
        {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(rd_valid == 1'b0, "R1", "rd_valid in reset", rd_valid, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(dram_ras_n && dram_cas_n && dram_we_n, "R1", "strobes after reset",
        {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    chk(s_ready == 1'b1, "R1", "ready after reset", s_ready, 1);
    chk(rd_valid == 1'b0, "R1", "rd_valid after reset", rd_valid, 0);
    mon_on = 1'b1;

    // directed: single read beat, then a write/read pair in one row (R7 closes)
    burst(1, 0, 1'b0);
    burst(2, 0, 1'b0);
    repeat (20) @(negedge clk);

    // R8: ten back-to-back beats need three row openings
    o0 = opens;
    burst(10, 0, 1'b0);
    repeat (60) @(negedge clk);
    chk(opens - o0 == 3, "R8", "row openings for ten beats", opens - o0, 3);

    // R9: long host pauses force time-limit closes on the same row
    o0 = opens;
    burst(3, 40, 1'b0);
    repeat (60) @(negedge clk);
    chk(opens - o0 == 3, "R9", "row openings with long pauses", opens - o0, 3);

    // R7: a burst right after another opens its own row
    burst(3, 0, 1'b1);
    burst(3, 0, 1'b1);

    // random bursts
    for (int k = 0; k < 80; k++) begin
      int n, g;
      n = 1 + int'($urandom % 7);
      g = (($urandom % 8) == 0) ? 12 : int'($urandom % 3);
      burst(n, g, 1'b1);
      repeat (int'($urandom % 4)) @(negedge clk);
    end

    repeat (80) @(negedge clk);
    chk(beat_q.size() == 0, "R2", "beats left unissued", beat_q.size(), 0);
    chk(rd_q.size() == 0, "R6", "reads left unanswered", rd_q.size(), 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule